// File: doc/BRIEF.md
# Register-to-Register Add/Subtract Unit

This block holds two 4-bit operand registers, an accumulator-style register A and a source register B, and one ripple-carry adder whose sum can be written back into A together with a registered carry flag. Before reaching the adder, each operand passes an enable gate that can force it to zero. The B path also passes a word-wide XOR stage that inverts it. The adder carry-in is a control of its own, separate from the inversion. From these four controls the same adder performs add, subtract, increment, decrement, transfer and the one's and two's complement of B.

A small combinational decoder turns a 4-bit operation code into the gate, invert, carry-in and write-back pattern. External parallel-load ports write A and B directly. Each load has its own enable, and every operation takes one clock edge.

Top module: `rr_addsub`

## Requirements
- R1: A synchronous active-high `rst` clears A, B and the carry flag to zero at the next rising edge. It overrides every other input.
- R2: When `ld_b` is high, B takes `din_b` at the edge. Otherwise B holds its value, and no operation code ever changes B.
- R3: When `ld_a` is high, A takes `din_a` at the edge, and this has priority over any operation result. An external load of A leaves the carry flag unchanged.
- R4: Code 1 (add) writes A+B into A. The adder carry-out goes into the carry flag, so {carry, A} equals the 5-bit sum.
- R5: Code 2 (subtract) writes A + ~B + 1 into A. The carry flag is 1 exactly when A ≥ B, meaning no borrow.
- R6: Code 3 (increment A) writes A+1 with carry set when A was 15. Code 4 (decrement A) writes A−1 with carry set when A was not 0.
- R7: Code 5 writes ~B into A with carry 0. Code 6 writes the two's complement of B into A, with carry set only when B was 0.
- R8: Code 7 copies B into A with carry 0. Code 8 rewrites A with its own value and clears the carry.
- R9: Code 0, codes 9 to 15, or `op_valid` low leave A and the carry flag unchanged.
- R10: Results wrap modulo 16. For example, 9+9 leaves A=2 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies `op_code` for this cycle |
| op_code | input | 4 | Operation select (codes per R4–R9) |
| ld_a | input | 1 | Parallel load enable for A |
| din_a | input | W | Parallel load value for A |
| ld_b | input | 1 | Parallel load enable for B |
| din_b | input | W | Parallel load value for B |
| ra_q | output | W | Register A |
| rb_q | output | W | Register B |
| cy_q | output | 1 | Registered carry-out flag |

## Verification
Every register feeds a port directly, so a wrong internal value shows up on `ra_q`, `rb_q` or `cy_q` one edge after the stimulus that caused it. A wrong decoder pattern or adder chain appears at that same edge as a wrong sum or carry. A stale register appears as a value that does not follow the load or hold rules. Operand pairs are chosen so that each control combination gives a distinct result, and so that the carry, borrow and wrap boundaries are all crossed.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    parameter int unsigned OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_INCA  = 4'd3,
        OP_DECA  = 4'd4,
        OP_ONESB = 4'd5,
        OP_TWOSB = 4'd6,
        OP_MOVB  = 4'd7,
        OP_MOVA  = 4'd8
    } op_e;

    typedef struct packed {
        logic gate_a;
        logic gate_b;
        logic invert_b;
        logic carry_in;
        logic write_a;
    } ctl_s;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
    import addsub_pkg::*;
(
    input  logic           valid,
    input  logic [OPW-1:0] code,
    output ctl_s           ctl
);

    always_comb begin
        ctl = '0;
        case (code)
            OP_ADD:   ctl = '{gate_a: 1'b1, gate_b: 1'b1, invert_b: 1'b0, carry_in: 1'b0, write_a: 1'b1};
            OP_SUB:   ctl = '{gate_a: 1'b1, gate_b: 1'b1, invert_b: 1'b1, carry_in: 1'b1, write_a: 1'b1};
            OP_INCA:  ctl = '{gate_a: 1'b1, gate_b: 1'b0, invert_b: 1'b0, carry_in: 1'b1, write_a: 1'b1};
            OP_DECA:  ctl = '{gate_a: 1'b1, gate_b: 1'b0, invert_b: 1'b1, carry_in: 1'b0, write_a: 1'b1};
            OP_ONESB: ctl = '{gate_a: 1'b0, gate_b: 1'b1, invert_b: 1'b1, carry_in: 1'b0, write_a: 1'b1};
            OP_TWOSB: ctl = '{gate_a: 1'b0, gate_b: 1'b1, invert_b: 1'b1, carry_in: 1'b1, write_a: 1'b1};
            OP_MOVB:  ctl = '{gate_a: 1'b0, gate_b: 1'b1, invert_b: 1'b0, carry_in: 1'b0, write_a: 1'b1};
            OP_MOVA:  ctl = '{gate_a: 1'b1, gate_b: 1'b0, invert_b: 1'b0, carry_in: 1'b0, write_a: 1'b1};
            default:  ctl = '0;
        endcase
        if (!valid) begin
            ctl.write_a = 1'b0;
        end
    end

endmodule

// File: rtl/addsub_operands.sv
// Operand conditioning: AND gating on both paths, then XOR inversion on B.
module addsub_operands #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         gate_a,
    input  logic         gate_b,
    input  logic         invert_b,
    output logic [W-1:0] a_op,
    output logic [W-1:0] b_op
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign a_op[i] = a_in[i] & gate_a;
        assign b_op[i] = (b_in[i] & gate_b) ^ invert_b;
    end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] carry;
    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign cout = carry[W];

endmodule

// File: rtl/rr_addsub.sv
module rr_addsub
    import addsub_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic           ld_a,
    input  logic [W-1:0]   din_a,
    input  logic           ld_b,
    input  logic [W-1:0]   din_b,
    output logic [W-1:0]   ra_q,
    output logic [W-1:0]   rb_q,
    output logic           cy_q
);

    typedef struct packed {
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic         cy;
    } state_s;

    state_s state_d, state_q;
    ctl_s   ctl;
    logic [W-1:0] a_op, b_op, sum;
    logic         cout;

    addsub_decode u_dec (
        .valid (op_valid),
        .code  (op_code),
        .ctl   (ctl)
    );

    addsub_operands #(.W(W)) u_opnd (
        .a_in     (state_q.ra),
        .b_in     (state_q.rb),
        .gate_a   (ctl.gate_a),
        .gate_b   (ctl.gate_b),
        .invert_b (ctl.invert_b),
        .a_op     (a_op),
        .b_op     (b_op)
    );

    addsub_ripple #(.W(W)) u_add (
        .x    (a_op),
        .y    (b_op),
        .cin  (ctl.carry_in),
        .sum  (sum),
        .cout (cout)
    );

    always_comb begin
        state_d = state_q;
        if (ld_b) begin
            state_d.rb = din_b;
        end
        if (ld_a) begin
            state_d.ra = din_a;
        end else if (ctl.write_a) begin
            state_d.ra = sum;
            state_d.cy = cout;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign ra_q = state_q.ra;
    assign rb_q = state_q.rb;
    assign cy_q = state_q.cy;

endmodule

// File: rtl/rr_addsub_chk.sv
module rr_addsub_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic         ld_a,
    input logic [W-1:0] din_a,
    input logic         ld_b,
    input logic [W-1:0] din_b,
    input logic [W-1:0] ra_q,
    input logic [W-1:0] rb_q,
    input logic         cy_q
);

    logic known_op;
    assign known_op = op_valid && (op_code >= 4'd1) && (op_code <= 4'd8);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ra_q == '0 && rb_q == '0 && !cy_q));

    p_load_b_r2: assert property (@(posedge clk) disable iff (rst)
        ld_b |=> rb_q == $past(din_b));

    p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
        !ld_b |=> $stable(rb_q));

    p_load_a_first_r3: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> (ra_q == $past(din_a) && cy_q == $past(cy_q)));

    p_add_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (!ld_a && op_valid && op_code == 4'd1)
        |=> {cy_q, ra_q} == {1'b0, $past(ra_q)} + {1'b0, $past(rb_q)});

    p_sub_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (!ld_a && op_valid && op_code == 4'd2)
        |=> {cy_q, ra_q} == {1'b0, $past(ra_q)} + {1'b0, ~$past(rb_q)} + {{W{1'b0}}, 1'b1});

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ld_a && !known_op) |=> ($stable(ra_q) && $stable(cy_q)));

endmodule

bind rr_addsub rr_addsub_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .ld_a     (ld_a),
    .din_a    (din_a),
    .ld_b     (ld_b),
    .din_b    (din_b),
    .ra_q     (ra_q),
    .rb_q     (rb_q),
    .cy_q     (cy_q)
);

// File: tb/rr_addsub_test.sv
module rr_addsub_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic         ld_a = 1'b0;
    logic [W-1:0] din_a = '0;
    logic         ld_b = 1'b0;
    logic [W-1:0] din_b = '0;
    logic [W-1:0] ra_q, rb_q;
    logic         cy_q;

    always #5 clk = ~clk;

    rr_addsub #(.W(W)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .ld_a(ld_a), .din_a(din_a), .ld_b(ld_b), .din_b(din_b),
        .ra_q(ra_q), .rb_q(rb_q), .cy_q(cy_q)
    );

    typedef struct {
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic         cy;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    int   m_ra = 0, m_rb = 0, m_cy = 0;

    // Driver: set inputs at the falling edge, predict the next register state.
    task automatic step(input bit r, input bit la, input int da, input bit lb, input int db,
                        input bit v, input int code, input string tag);
        int nra, nrb, ncy;
        exp_t e;
        @(negedge clk);
        rst = r; ld_a = la; din_a = 4'(da); ld_b = lb; din_b = 4'(db);
        op_valid = v; op_code = 4'(code);
        nra = m_ra; nrb = lb ? db : m_rb; ncy = m_cy;
        if (la) begin
            nra = da;
        end else if (v) begin
            case (code)
                1: begin nra = (m_ra + m_rb) % 16; ncy = (m_ra + m_rb) > 15; end
                2: begin nra = (m_ra - m_rb + 16) % 16; ncy = (m_ra >= m_rb); end
                3: begin nra = (m_ra + 1) % 16; ncy = (m_ra == 15); end
                4: begin nra = (m_ra + 15) % 16; ncy = (m_ra != 0); end
                5: begin nra = 15 - m_rb; ncy = 0; end
                6: begin nra = (16 - m_rb) % 16; ncy = (m_rb == 0); end
                7: begin nra = m_rb; ncy = 0; end
                8: begin nra = m_ra; ncy = 0; end
                default: ;
            endcase
        end
        if (r) begin nra = 0; nrb = 0; ncy = 0; end
        m_ra = nra; m_rb = nrb; m_cy = ncy;
        e.ra = 4'(nra); e.rb = 4'(nrb); e.cy = 1'(ncy); e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one edge after each driven cycle, compare against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (ra_q !== e.ra || rb_q !== e.rb || cy_q !== e.cy) begin
                    fails++;
                    $display("FAIL %s: got ra=%0d rb=%0d cy=%0d, expected ra=%0d rb=%0d cy=%0d",
                             e.tag, ra_q, rb_q, cy_q, e.ra, e.rb, e.cy);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, 0, "R1 reset");
        step(0, 1, 5, 1, 10, 0, 0, "R2 R3 parallel load");
        step(0, 0, 0, 0, 0, 1, 1, "R4 add 5+10");
        step(0, 1, 9, 1, 9, 0, 0, "R2 R3 reload");
        step(0, 0, 0, 0, 0, 1, 1, "R10 add wrap 9+9");
        step(0, 0, 0, 0, 0, 1, 0, "R9 nop holds");
        step(0, 0, 0, 0, 0, 1, 12, "R9 unused code holds");
        step(0, 0, 0, 0, 0, 0, 1, "R9 invalid op holds");
        step(0, 1, 3, 0, 0, 1, 1, "R3 load beats add, carry kept");
        step(0, 0, 0, 1, 7, 1, 2, "R5 sub 3-9 borrow, R2 load b");
        step(0, 0, 0, 0, 0, 1, 2, "R5 sub 10-7 no borrow");
        step(0, 1, 15, 0, 0, 1, 3, "R3 set a=15");
        step(0, 0, 0, 0, 0, 1, 3, "R6 inc 15 wraps");
        step(0, 0, 0, 0, 0, 1, 4, "R6 dec 0 wraps");
        step(0, 0, 0, 0, 0, 1, 4, "R6 dec 15");
        step(0, 0, 0, 0, 0, 1, 5, "R7 ones complement b");
        step(0, 0, 0, 0, 0, 1, 6, "R7 twos complement b");
        step(0, 0, 0, 1, 0, 0, 0, "R2 b=0");
        step(0, 0, 0, 0, 0, 1, 6, "R7 twos complement of zero");
        step(0, 0, 0, 1, 11, 0, 0, "R2 b=11");
        step(0, 0, 0, 0, 0, 1, 7, "R8 move b to a");
        step(0, 0, 0, 0, 0, 1, 3, "R6 inc 11");
        step(0, 0, 0, 0, 0, 1, 8, "R8 move a clears carry");
        step(0, 0, 0, 0, 0, 1, 15, "R9 code 15 holds, R2 b held");
        step(1, 1, 4, 1, 4, 1, 1, "R1 reset overrides");
        step(0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule